// File: doc/BRIEF.md
# DRAM Frequency Switch Sequencer

This block carries out a DRAM clock change when software asks for one. Software first programs the timing registers, usually with buffering turned on so that the new values are held in shadow copies. It then sets a start bit in the control register. The hardware takes over from there. It waits until every bus master that is not masked reports ready. It can optionally clamp the DRAM pads. It asks an external clock generator to move to the new setting and waits for that generator to acknowledge. It then copies all shadow timing values into the active registers in one cycle, releases the pads and clears the start bit.

Software polls the start bit to learn when the switch is done. After that it writes zero to the control register so that later timing writes take effect at once again. The PLL, the PHY and the memory controller sit outside this block. The block only presents the active timing values and the handshakes.

Top module: `dram_freq_switch`

## Requirements
- R1: After reset the control register, the mask register and every active timing register read 0, and `clkSwReq`, `padHold` and `commitStrobe` are low.
- R2: A write to the control register (byte offset 0x00) with bit 0 set, made while bit 0 reads 0, launches a sequence. Bit 0 reads 1 from the next cycle and clears by itself once the sequence has finished.
- R3: A launched sequence does not raise `clkSwReq` until, for every master i, `masterReady[i]` or mask bit i is 1. The mask register is at byte offset 0x04, and a mask bit of 1 ignores that master.
- R4: `clkSwReq` stays high until the cycle in which `clkSwAck` is sampled high. While it is high, `clkMode` equals control bit 1 and `clkBypass` equals control bit 2.
- R5: With control bit 3 set, `padHold` is high for exactly one cycle before the request, for every request cycle, and for the commit cycle. With bit 3 clear, `padHold` is never high.
- R6: While control bit 4 (buffered) is 1, a write to timing register i (byte offset 0x08 + 4*i) leaves its active value, as read back, unchanged.
- R7: After the acknowledge, `commitStrobe` pulses for exactly one cycle. Every active timing register takes its shadow value on that same edge. The start bit clears after that edge.
- R8: While control bit 4 is 0, a timing write takes effect in the active register at the write edge.
- R9: Any write to the control register while bit 0 reads 1 is ignored: none of the fields changes.
- R10: Timing register 0 holds the refresh settings. Bits [31:16] drive `refInterval` (the interval in units of 32 clocks) and bits [15:0] drive `refCycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| masterReady | input | NUM_MASTERS | Per-master ready-to-switch flags |
| clkSwReq | output | 1 | Clock switch request |
| clkSwAck | input | 1 | Clock switch acknowledge |
| clkMode | output | 1 | Requested switch mode (control bit 1) |
| clkBypass | output | 1 | Requested clock bypass (control bit 2) |
| padHold | output | 1 | DRAM pad clamp |
| commitStrobe | output | 1 | One-cycle shadow-to-active commit pulse |
| timingActive | output | NUM_TIMING*32 | Active timing registers, register i at bits [32*i+31:32*i] |
| refInterval | output | 16 | Refresh interval in 32-clock units |
| refCycles | output | 16 | Refresh cycle time in clocks |

## Verification
The bench builds the block with four masters and three timing registers. This makes it possible to try a master that is only partly ready against a mask, a fully masked set with no master ready, and a commit that has to move three distinct shadow values together. The acknowledge responder can be delayed by a chosen number of cycles. The bench uses this to stretch the request, and then counts pad-hold and request cycles against the lengths that R4 and R5 predict.

// File: rtl/dfs_pkg.sv
package dfs_pkg;
  localparam int CTRL_START = 0;
  localparam int CTRL_MODE  = 1;
  localparam int CTRL_BYP   = 2;
  localparam int CTRL_PAD   = 3;
  localparam int CTRL_BUF   = 4;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_WAIT,
    SEQ_HOLD,
    SEQ_SWITCH,
    SEQ_COMMIT,
    SEQ_RELEASE
  } seq_state_t;

  typedef struct packed {
    logic commit;
    logic done;
  } seq_strobe_t;
endpackage

// File: rtl/dfs_regs.sv
module dfs_regs
  import dfs_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_TIMING  = 3,
  parameter int ADDR_W      = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [31:0]                wrData,
  output logic [31:0]                rdData,
  input  seq_strobe_t                strobes,
  output logic                       startBit,
  output logic                       ctrlMode,
  output logic                       ctrlBypass,
  output logic                       padHoldEn,
  output logic [NUM_MASTERS-1:0]     mask,
  output logic [NUM_TIMING*32-1:0]   timingActive
);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] MASK_OFF = ADDR_W'(4);
  localparam int                TIM_BASE = 8;

  logic bufEn;
  logic ctrlSel, maskSel;
  logic [NUM_TIMING-1:0] timSel;
  logic [31:0] shadow [NUM_TIMING];
  logic [31:0] active [NUM_TIMING];

  assign ctrlSel = wrEn && (addr == CTRL_OFF);
  assign maskSel = wrEn && (addr == MASK_OFF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startBit   <= 1'b0;
      ctrlMode   <= 1'b0;
      ctrlBypass <= 1'b0;
      padHoldEn  <= 1'b0;
      bufEn      <= 1'b0;
      mask       <= '0;
    end else begin
      if (strobes.done) begin
        startBit <= 1'b0;
      end else if (ctrlSel && !startBit) begin
        startBit   <= wrData[CTRL_START];
        ctrlMode   <= wrData[CTRL_MODE];
        ctrlBypass <= wrData[CTRL_BYP];
        padHoldEn  <= wrData[CTRL_PAD];
        bufEn      <= wrData[CTRL_BUF];
      end
      if (maskSel) mask <= wrData[NUM_MASTERS-1:0];
    end
  end

  for (genvar i = 0; i < NUM_TIMING; i++) begin : g_tim
    assign timSel[i] = wrEn && (addr == ADDR_W'(TIM_BASE + 4*i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shadow[i] <= '0;
        active[i] <= '0;
      end else begin
        if (strobes.commit) active[i] <= shadow[i];
        if (timSel[i]) begin
          shadow[i] <= wrData;
          if (!bufEn) active[i] <= wrData;
        end
      end
    end
    assign timingActive[32*i +: 32] = active[i];

    // R6 R8: an active value moves only through a commit or an unbuffered write
    assert_active_source_R6: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(active[i]) |-> ($past(strobes.commit) || $past(timSel[i] && !bufEn)));
  end

  always_comb begin
    rdData = '0;
    if (addr == CTRL_OFF) begin
      rdData[CTRL_START] = startBit;
      rdData[CTRL_MODE]  = ctrlMode;
      rdData[CTRL_BYP]   = ctrlBypass;
      rdData[CTRL_PAD]   = padHoldEn;
      rdData[CTRL_BUF]   = bufEn;
    end else if (addr == MASK_OFF) begin
      rdData[NUM_MASTERS-1:0] = mask;
    end
    for (int i = 0; i < NUM_TIMING; i++)
      if (addr == ADDR_W'(TIM_BASE + 4*i)) rdData = active[i];
  end

  assert_ctrl_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(startBit) |-> ($stable(ctrlMode) && $stable(ctrlBypass) && $stable(padHoldEn) && $stable(bufEn)));

  assert_done_after_commit_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |-> $past(strobes.commit, 2));
endmodule

// File: rtl/dfs_ctrl.sv
module dfs_ctrl
  import dfs_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startBit,
  input  logic                   padHoldEn,
  input  logic [NUM_MASTERS-1:0] masterReady,
  input  logic [NUM_MASTERS-1:0] mask,
  input  logic                   clkSwAck,
  output logic                   clkSwReq,
  output logic                   padHold,
  output seq_strobe_t            strobes
);
  seq_state_t state, nextState;
  logic allReady;

  assign allReady = &(masterReady | mask);

  always_comb begin
    nextState = state;
    unique case (state)
      SEQ_IDLE:    if (startBit) nextState = SEQ_WAIT;
      SEQ_WAIT:    if (allReady) nextState = SEQ_HOLD;
      SEQ_HOLD:    nextState = SEQ_SWITCH;
      SEQ_SWITCH:  if (clkSwAck) nextState = SEQ_COMMIT;
      SEQ_COMMIT:  nextState = SEQ_RELEASE;
      SEQ_RELEASE: nextState = SEQ_IDLE;
      default:     nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  assign clkSwReq       = (state == SEQ_SWITCH);
  assign padHold        = padHoldEn &&
                          (state == SEQ_HOLD || state == SEQ_SWITCH || state == SEQ_COMMIT);
  assign strobes.commit = (state == SEQ_COMMIT);
  assign strobes.done   = (state == SEQ_RELEASE);

  assert_req_after_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSwReq) |-> $past(allReady, 2));

  assert_req_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkSwReq && !clkSwAck) |=> clkSwReq);

  assert_pad_covers_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clkSwReq && padHoldEn) |-> padHold);

  assert_commit_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |=> !strobes.commit);
endmodule

// File: rtl/dram_freq_switch.sv
module dram_freq_switch
  import dfs_pkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int NUM_TIMING  = 3,
  parameter int ADDR_W      = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     regWrEn,
  input  logic [ADDR_W-1:0]        regAddr,
  input  logic [31:0]              regWrData,
  output logic [31:0]              regRdData,
  input  logic [NUM_MASTERS-1:0]   masterReady,
  output logic                     clkSwReq,
  input  logic                     clkSwAck,
  output logic                     clkMode,
  output logic                     clkBypass,
  output logic                     padHold,
  output logic                     commitStrobe,
  output logic [NUM_TIMING*32-1:0] timingActive,
  output logic [15:0]              refInterval,
  output logic [15:0]              refCycles
);
  seq_strobe_t strobes;
  logic startBit, padHoldEn;
  logic [NUM_MASTERS-1:0] mask;

  dfs_regs #(.NUM_MASTERS(NUM_MASTERS), .NUM_TIMING(NUM_TIMING), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .strobes(strobes), .startBit(startBit), .ctrlMode(clkMode),
    .ctrlBypass(clkBypass), .padHoldEn(padHoldEn), .mask(mask), .timingActive(timingActive)
  );

  dfs_ctrl #(.NUM_MASTERS(NUM_MASTERS)) u_ctrl (
    .clk(clk), .rstN(rstN), .startBit(startBit), .padHoldEn(padHoldEn),
    .masterReady(masterReady), .mask(mask), .clkSwAck(clkSwAck),
    .clkSwReq(clkSwReq), .padHold(padHold), .strobes(strobes)
  );

  assign commitStrobe = strobes.commit;
  assign refInterval  = timingActive[31:16];
  assign refCycles    = timingActive[15:0];
endmodule

// File: tb/sim_dram_freq_switch.sv
module sim_dram_freq_switch;
  localparam int NM = 4;
  localparam int NT = 3;
  localparam int AW = 8;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [NM-1:0] masterReady = '0;
  logic clkSwReq, clkSwAck = 0, clkMode, clkBypass, padHold, commitStrobe;
  logic [NT*32-1:0] timingActive;
  logic [15:0] refInterval, refCycles;

  int tests = 0, fails = 0;
  int ackDelay = 0, reqRun = 0;
  int reqCycles = 0, padCycles = 0, commitCycles = 0, padNoReqBad = 0;
  logic modeAtReq = 0, bypAtReq = 0;
  logic [NT*32-1:0] activeAtCommit = '0;

  always #10 clk = ~clk;

  dram_freq_switch #(.NUM_MASTERS(NM), .NUM_TIMING(NT), .ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .masterReady(masterReady), .clkSwReq(clkSwReq), .clkSwAck(clkSwAck),
    .clkMode(clkMode), .clkBypass(clkBypass), .padHold(padHold), .commitStrobe(commitStrobe),
    .timingActive(timingActive), .refInterval(refInterval), .refCycles(refCycles)
  );

  // acknowledge responder and monitor
  always @(negedge clk) begin
    if (clkSwReq) begin
      clkSwAck  <= (reqRun >= ackDelay);
      reqRun    <= reqRun + 1;
      reqCycles <= reqCycles + 1;
      modeAtReq <= clkMode;
      bypAtReq  <= clkBypass;
    end else begin
      clkSwAck <= 1'b0;
      reqRun   <= 0;
    end
    if (padHold) padCycles <= padCycles + 1;
    if (commitStrobe) begin
      commitCycles   <= commitCycles + 1;
      activeAtCommit <= timingActive;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    reqCycles = 0; padCycles = 0; commitCycles = 0;
  endtask

  task automatic regWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic regRead(input logic [AW-1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone(output bit ok);
    logic [31:0] v;
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      regRead(8'h00, v);
      if (!v[0]) begin ok = 1; break; end
    end
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(8'h00, v); check(v == 0, "R1 ctrl", v, 0);
    regRead(8'h04, v); check(v == 0, "R1 mask", v, 0);
    regRead(8'h08, v); check(v == 0, "R1 timing0", v, 0);
    check({clkSwReq, padHold, commitStrobe} == 0, "R1 outputs", {clkSwReq, padHold, commitStrobe}, 0);
  endtask

  task automatic testUnbuffered();
    logic [31:0] v;
    regWrite(8'h08, 32'h0040_0012);
    regRead(8'h08, v); check(v == 32'h0040_0012, "R8 immediate", v, 32'h0040_0012);
    check(refInterval == 16'h0040, "R10 interval", refInterval, 16'h0040);
    check(refCycles == 16'h0012, "R10 cycles", refCycles, 16'h0012);
  endtask

  task automatic testGatedBuffered();
    logic [31:0] v;
    bit ok;
    masterReady = 4'b0111;
    regWrite(8'h00, 32'h10);          // buffered on, no start
    regWrite(8'h08, 32'h0080_0033);
    regWrite(8'h0C, 32'hAAAA_0001);
    regWrite(8'h10, 32'h5555_0002);
    regRead(8'h08, v); check(v == 32'h0040_0012, "R6 timing0 held", v, 32'h0040_0012);
    regRead(8'h0C, v); check(v == 0, "R6 timing1 held", v, 0);
    clearMon();
    ackDelay = 3;
    regWrite(8'h00, 32'h1B);          // start, mode, pad, buffered
    regRead(8'h00, v); check(v[0] == 1, "R2 start reads 1", v, 32'h1B);
    regWrite(8'h00, 32'h00);          // must be ignored
    regRead(8'h00, v); check(v == 32'h1B, "R9 ctrl write ignored", v, 32'h1B);
    repeat (20) @(negedge clk);
    check(reqCycles == 0, "R3 blocked by unready master", reqCycles, 0);
    regRead(8'h00, v); check(v[0] == 1, "R3 still running", v, 1);
    masterReady = 4'b1111;
    waitDone(ok);
    check(ok, "R2 start self-clears", ok, 1);
    check(reqCycles == 4, "R4 request held until ack", reqCycles, 4);
    check(modeAtReq == 1 && bypAtReq == 0, "R4 mode/bypass", {modeAtReq, bypAtReq}, 2'b10);
    check(padCycles == 6, "R5 pad hold span", padCycles, 6);
    check(commitCycles == 1, "R7 single commit", commitCycles, 1);
    check(activeAtCommit[31:0] == 32'h0040_0012, "R7 old value during commit", activeAtCommit[31:0], 32'h0040_0012);
    regRead(8'h08, v); check(v == 32'h0080_0033, "R7 timing0 committed", v, 32'h0080_0033);
    regRead(8'h0C, v); check(v == 32'hAAAA_0001, "R7 timing1 committed", v, 32'hAAAA_0001);
    regRead(8'h10, v); check(v == 32'h5555_0002, "R7 timing2 committed", v, 32'h5555_0002);
    check(refInterval == 16'h0080, "R10 after commit", refInterval, 16'h0080);
    regWrite(8'h00, 32'h0);
    regWrite(8'h10, 32'h0000_0777);
    regRead(8'h10, v); check(v == 32'h0000_0777, "R8 after buffering off", v, 32'h0000_0777);
  endtask

  task automatic testMaskedNoPad();
    logic [31:0] v;
    bit ok;
    masterReady = 4'b0000;
    regWrite(8'h04, 32'hF);
    regRead(8'h04, v); check(v == 32'hF, "R3 mask readback", v, 32'hF);
    clearMon();
    ackDelay = 0;
    regWrite(8'h00, 32'h05);          // start, bypass, no pad
    waitDone(ok);
    check(ok, "R3 fully masked completes", ok, 1);
    check(reqCycles == 1, "R4 immediate ack", reqCycles, 1);
    check(bypAtReq == 1 && modeAtReq == 0, "R4 bypass", {modeAtReq, bypAtReq}, 2'b01);
    check(padCycles == 0, "R5 pad never asserted", padCycles, 0);
    check(commitCycles == 1, "R7 commit pulse", commitCycles, 1);
  endtask

  task automatic testPartialMask();
    bit ok;
    masterReady = 4'b0101;
    regWrite(8'h04, 32'h8);
    clearMon();
    regWrite(8'h00, 32'h09);
    repeat (15) @(negedge clk);
    check(reqCycles == 0, "R3 unmasked master 1 blocks", reqCycles, 0);
    regWrite(8'h04, 32'hA);
    waitDone(ok);
    check(ok, "R3 partial mask completes", ok, 1);
    check(padCycles == 3, "R5 pad span one-cycle ack", padCycles, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testUnbuffered();
    testGatedBuffered();
    testMaskedNoPad();
    testPartialMask();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule